// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture and Aggregator

This block sits on the inbound memory-write path of a host bridge. It compares every accepted write against a programmable 64-bit target address. When a write hits that address and capture is switched on, the value carried in the write data is taken as a vector number. The block records it as one pending bit out of 64. The pending bits form two banks of 32: vectors 0 to 31 sit in the low bank and vectors 32 to 63 in the high bank. Each bank has its own enable mask and its own level interrupt output.

Software uses a 32-bit register port. Through it, software programs the target address, turns capture on, enables vectors bank by bank, and acknowledges pending vectors by writing ones to the status words. Register reads are combinational from the address. Writes take effect at the next rising clock edge.

The inbound write interface is valid/ready. The block never back-pressures: `in_ready` is held high, and a write is consumed in every cycle where `in_valid` is high. The upstream source may hold or drop `in_valid` freely. Data sent to any other address is consumed and dropped.

Top module: `msi_capture_agg`

## Requirements
- R1: After reset the capability word (offset 0x300) reads 1 in bit 0. Control, both masks and both status words read 0. Both interrupt outputs and `vec_err` are low.
- R2: A write is recorded only when control (offset 0x308) has bit 0 (capture enable) and bit 15 (status-record enable) both set. With either bit clear, no status bit changes.
- R3: A write hits only when its 64-bit address equals {base high word (0x314), base low word (0x310)}. A write to any other address changes no status bit.
- R4: A hitting write with data value v below 64 sets status bit v. For v below 32 this is bit v of the low status word (0x440). Otherwise it is bit v-32 of the high status word (0x444). One cycle after the write is accepted, the bit reads as set.
- R5: A hitting write with a data value of 64 or more changes no status bit. It sets `vec_err`, which stays high until reset.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R7: When an inbound set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_lo` is high exactly when some low status bit and the matching low mask bit (0x448, 1 = enabled) are both 1; `irq_hi` behaves the same way with the high words (0x44C). A masked vector still records its status, and it raises the output as soon as its mask bit is set.
- R9: `in_ready` is high whenever reset is released, so every valid write is consumed.
- R10: Base and mask words read back what was written. Control reads back only bits 0 and 15. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound memory write present |
| in_ready | output | 1 | Block accepts the inbound write (always high) |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data, vector number |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq_lo | output | 1 | Level interrupt, vectors 0 to 31 |
| irq_hi | output | 1 | Level interrupt, vectors 32 to 63 |
| vec_err | output | 1 | Sticky flag for an out-of-range vector |

## Verification
The main pattern table sends hitting writes at both edges of each bank (vectors 0, 31, 32, 63) and at interior vectors. These show that the bank split and the bit position are right. Misses that differ only in the low address word, or only in the high word, show that all 64 address bits are compared. Directed runs then cover each possible setting of the two control bits on its own. They check that status is recorded under mask and the output rises when the mask is enabled, and that each bank's output is independent of the other. They also check write-one-to-clear against write-zero, a set and a clear on the same bit in the same cycle, and an out-of-range vector.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned REG_AW    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned NUM_VEC   = BANK_W * NUM_BANKS;
  localparam int unsigned VEC_IDX_W = $clog2(NUM_VEC);

  localparam logic [REG_AW-1:0] OFS_CAPS    = 12'h300;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h308;
  localparam logic [REG_AW-1:0] OFS_TGT_LO  = 12'h310;
  localparam logic [REG_AW-1:0] OFS_TGT_HI  = 12'h314;
  localparam logic [REG_AW-1:0] OFS_PEND0   = 12'h440;
  localparam logic [REG_AW-1:0] OFS_ENA0    = OFS_PEND0 + REG_AW'(4 * NUM_BANKS);

  localparam int unsigned CTRL_CAPTURE_BIT = 0;
  localparam int unsigned CTRL_RECORD_BIT  = 15;
endpackage

// File: rtl/msi_target_decode.sv
module msi_target_decode
  import msi_cap_pkg::*;
#(
  parameter int unsigned NVEC = NUM_VEC
) (
  input  logic              fire_i,
  input  logic              arm_i,
  input  logic [63:0]       addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [63:0]       target_i,
  output logic [NVEC-1:0]   set_vec_o,
  output logic              bad_vec_o
);
  localparam int unsigned IW = $clog2(NVEC);

  logic hit;
  logic in_range;

  always_comb begin
    hit       = fire_i && arm_i && (addr_i == target_i);
    in_range  = (data_i < DATA_W'(NVEC));
    set_vec_o = '0;
    if (hit && in_range) set_vec_o[data_i[IW-1:0]] = 1'b1;
    bad_vec_o = hit && !in_range;
  end
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         ena_we_i,
  input  logic [W-1:0] ena_wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] ena_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] ena_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ena_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;
      if (ena_we_i) ena_q <= ena_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;
  assign irq_o  = |(pend_q & ena_q);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/msi_capture_agg.sv
module msi_capture_agg
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              vec_err
);
  logic              cap_en_q, rec_en_q;
  logic [31:0]       tgt_lo_q, tgt_hi_q;
  logic              err_q;
  logic              arm;
  logic [NUM_VEC-1:0] set_vec;
  logic              bad_vec;
  logic [BANK_W-1:0] pend [NUM_BANKS];
  logic [BANK_W-1:0] ena  [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_b;
  logic [NUM_VEC-1:0] pend_all;

  assign in_ready = rst_n;
  assign arm      = cap_en_q && rec_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en_q <= 1'b0;
      rec_en_q <= 1'b0;
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_CTRL) begin
        cap_en_q <= reg_wdata[CTRL_CAPTURE_BIT];
        rec_en_q <= reg_wdata[CTRL_RECORD_BIT];
      end
      if (reg_we && reg_addr == OFS_TGT_LO) tgt_lo_q <= reg_wdata;
      if (reg_we && reg_addr == OFS_TGT_HI) tgt_hi_q <= reg_wdata;
      if (bad_vec) err_q <= 1'b1;
    end
  end

  msi_target_decode #(.NVEC(NUM_VEC)) u_decode (
    .fire_i    (in_valid && in_ready),
    .arm_i     (arm),
    .addr_i    (in_addr),
    .data_i    (in_data),
    .target_i  ({tgt_hi_q, tgt_lo_q}),
    .set_vec_o (set_vec),
    .bad_vec_o (bad_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [REG_AW-1:0] PEND_OFS = OFS_PEND0 + REG_AW'(4 * b);
    localparam logic [REG_AW-1:0] ENA_OFS  = OFS_ENA0  + REG_AW'(4 * b);
    logic [BANK_W-1:0] clr;
    assign clr = (reg_we && reg_addr == PEND_OFS) ? reg_wdata : '0;

    msi_pend_bank #(.W(BANK_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_vec[b*BANK_W +: BANK_W]),
      .clr_i       (clr),
      .ena_we_i    (reg_we && reg_addr == ENA_OFS),
      .ena_wdata_i (reg_wdata),
      .pend_o      (pend[b]),
      .ena_o       (ena[b]),
      .irq_o       (irq_b[b])
    );
    assign pend_all[b*BANK_W +: BANK_W] = pend[b];
  end

  assign irq_lo  = irq_b[0];
  assign irq_hi  = irq_b[NUM_BANKS-1];
  assign vec_err = err_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CAPS:   reg_rdata = 32'h1;
      OFS_CTRL: begin
        reg_rdata[CTRL_CAPTURE_BIT] = cap_en_q;
        reg_rdata[CTRL_RECORD_BIT]  = rec_en_q;
      end
      OFS_TGT_LO: reg_rdata = tgt_lo_q;
      OFS_TGT_HI: reg_rdata = tgt_hi_q;
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (reg_addr == OFS_PEND0 + REG_AW'(4 * b)) reg_rdata = pend[b];
          if (reg_addr == OFS_ENA0 + REG_AW'(4 * b))  reg_rdata = ena[b];
        end
      end
    endcase
  end

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |=> vec_err);

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((pend_all & ~$past(pend_all)) == '0));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/tb_msi_capture_agg.sv
module tb_msi_capture_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi, vec_err;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] TG_LO = 32'hE000_0040;
  localparam logic [31:0] TG_HI = 32'h0000_00FE;
  localparam logic [63:0] TGT   = {TG_HI, TG_LO};

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
    logic [31:0] exp_lo;
    logic [31:0] exp_hi;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{TGT,                      32'd0,  32'h0000_0001, 32'h0},
    '{TGT,                      32'd31, 32'h8000_0000, 32'h0},
    '{TGT,                      32'd32, 32'h0,         32'h0000_0001},
    '{TGT,                      32'd63, 32'h0,         32'h8000_0000},
    '{TGT,                      32'd5,  32'h0000_0020, 32'h0},
    '{TGT,                      32'd40, 32'h0,         32'h0000_0100},
    '{{TG_HI, TG_LO ^ 32'h4},   32'd3,  32'h0,         32'h0},
    '{{TG_HI ^ 32'h1, TG_LO},   32'd3,  32'h0,         32'h0},
    '{{TG_LO, TG_HI},           32'd3,  32'h0,         32'h0},
    '{TGT,                      32'd17, 32'h0002_0000, 32'h0}
  };

  msi_capture_agg dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo),
    .irq_hi(irq_hi), .vec_err(vec_err)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_and_clear(input logic [63:0] a, input logic [31:0] d,
                                input logic [11:0] ra, input logic [31:0] rd_v);
    in_valid = 1'b1; in_addr = a; in_data = d;
    reg_we = 1'b1; reg_addr = ra; reg_wdata = rd_v;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic clear_all();
    wr(12'h440, 32'hFFFF_FFFF);
    wr(12'h444, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h300, d); check("R1 caps", 64'(d), 64'h1);
    rd(12'h308, d); check("R1 ctrl", 64'(d), 64'h0);
    rd(12'h448, d); check("R1 mask lo", 64'(d), 64'h0);
    rd(12'h44C, d); check("R1 mask hi", 64'(d), 64'h0);
    rd(12'h440, d); check("R1 stat lo", 64'(d), 64'h0);
    rd(12'h444, d); check("R1 stat hi", 64'(d), 64'h0);
    check("R1 irqs/err", {61'h0, irq_lo, irq_hi, vec_err}, 64'h0);
    check("R9 ready", 64'(in_ready), 64'h1);

    // R10 register readback
    wr(12'h310, TG_LO); wr(12'h314, TG_HI);
    rd(12'h310, d); check("R10 base lo", 64'(d), 64'(TG_LO));
    rd(12'h314, d); check("R10 base hi", 64'(d), 64'(TG_HI));
    wr(12'h308, 32'hFFFF_FFFF);
    rd(12'h308, d); check("R10 ctrl bits", 64'(d), 64'h8001);
    rd(12'h000, d); check("R10 unmapped", 64'(d), 64'h0);

    // R2 gating: each control bit alone
    wr(12'h308, 32'h0000_0001);
    send(TGT, 32'd4);
    rd(12'h440, d); check("R2 capture only", 64'(d), 64'h0);
    wr(12'h308, 32'h0000_8000);
    send(TGT, 32'd4);
    rd(12'h440, d); check("R2 record only", 64'(d), 64'h0);
    wr(12'h308, 32'h0000_8001);

    // R3 R4 table walk
    for (int i = 0; i < 10; i++) begin
      clear_all();
      send(TBL[i].addr, TBL[i].data);
      rd(12'h440, d); check($sformatf("R3/R4 row %0d lo", i), 64'(d), 64'(TBL[i].exp_lo));
      rd(12'h444, d); check($sformatf("R3/R4 row %0d hi", i), 64'(d), 64'(TBL[i].exp_hi));
    end

    // R8 masked recording, independent banks
    clear_all();
    send(TGT, 32'd9);
    rd(12'h440, d); check("R8 masked still recorded", 64'(d), 64'h200);
    check("R8 irq_lo masked", 64'(irq_lo), 64'h0);
    wr(12'h448, 32'hFFFF_FFFF);
    check("R8 irq_lo after enable", 64'(irq_lo), 64'h1);
    check("R8 irq_hi stays low", 64'(irq_hi), 64'h0);
    send(TGT, 32'd50);
    check("R8 irq_hi masked", 64'(irq_hi), 64'h0);
    wr(12'h44C, 32'h0004_0000);
    check("R8 irq_hi enabled bit", 64'(irq_hi), 64'h1);
    rd(12'h44C, d); check("R10 mask hi readback", 64'(d), 64'h0004_0000);

    // R6 write-one-to-clear
    wr(12'h440, 32'h0);
    rd(12'h440, d); check("R6 write zero keeps", 64'(d), 64'h200);
    wr(12'h440, 32'h200);
    rd(12'h440, d); check("R6 write one clears", 64'(d), 64'h0);
    check("R6 irq_lo drops", 64'(irq_lo), 64'h0);

    // R7 set wins over clear
    send(TGT, 32'd12);
    send_and_clear(TGT, 32'd12, 12'h440, 32'h0000_1000);
    rd(12'h440, d); check("R7 set wins", 64'(d), 64'h1000);
    send_and_clear(TGT, 32'd1, 12'h440, 32'h0000_1000);
    rd(12'h440, d); check("R7 other bit cleared", 64'(d), 64'h2);

    // R5 out-of-range vector
    check("R5 err low before", 64'(vec_err), 64'h0);
    send(TGT, 32'd64);
    check("R5 err set", 64'(vec_err), 64'h1);
    rd(12'h440, d); check("R5 lo unchanged", 64'(d), 64'h2);
    rd(12'h444, d); check("R5 hi unchanged", 64'(d), 64'h0004_0000);
    send(TGT, 32'd3);
    check("R5 err sticky", 64'(vec_err), 64'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule